// File: doc/BRIEF.md
# Byte-Wide Asynchronous DRAM Access Sequencer

This block turns single-byte read and write requests into the strobe sequence that an asynchronous, address-multiplexed DRAM expects. A requester offers a linear address, a direction flag and a write byte on a valid/ready handshake. The block splits the address into a row half and a column half and places each on a shared 12-bit address bus in turn. It walks the active-low row strobe, column strobe and write-enable through a fixed order. Writes drive the data byte out. Reads leave the bus released, sample the byte and return it with a one-cycle completion pulse.

Two settings are sampled when a request is accepted. The first is the number of address bits used per half, which sets where the linear address is split. The second picks which of two row-strobe lines serves the access. The same linear address can therefore reach different cells under different settings. Every timing phase lasts a parameterised number of clock cycles, and no phase is shorter than one cycle. The bidirectional data bus appears as separate output, output-enable and input pins, so an I/O buffer outside the block joins them.

Top module: `dram_byte_seq`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, `ras_n` is 2'b11, `cas_n` and `we_n` are 1, `dq_oe` is 0 and `done` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 through the whole access and the precharge that follows. With defaults, `req_ready` is low for 13 cycles on a write and 12 cycles on a read, counted from the acceptance edge.
- R3: The row address is the linear address shifted right by N and masked to N bits, where N is the effective bit count. It sits on `ma` when a row strobe falls. The column address is the linear address masked to N bits, and it sits on `ma` when `cas_n` falls. All `ma` bits at position N and above are 0.
- R4: The effective bit count N is `cfg_abits` clamped to the range 1..12. A value of 0 acts as 1, and values 13..15 act as 12.
- R5: When `cfg_ras_sel` is 2, the access uses `ras_n[1]`. Any other value uses `ras_n[0]`. No more than one row strobe is ever low.
- R6: A write lowers `we_n` and raises `dq_oe` with the write byte on `dq_out`, and both happen before any row strobe falls. When `cas_n` falls, `we_n` is 0, `dq_oe` is 1 and `dq_out` holds the byte. The release order after that is: the row strobe first, then `cas_n`, then `dq_oe`, then `we_n`. Each step lands on a separate cycle.
- R7: During a read, `we_n` stays 1 and `dq_oe` stays 0. The byte on `dq_in` is sampled in the last column-strobe cycle. `done` pulses for one cycle with that byte on `rd_data`, 9 cycles after the acceptance edge with defaults. A write never raises `done`.
- R8: `ma` holds the same value for at least the one cycle before each falling row strobe and each falling column strobe.
- R9: Address, direction, write data, bit count and strobe selection are captured at acceptance. Changes to these inputs while an access is in progress have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Linear byte address |
| req_wdata | input | 8 | Byte to write |
| cfg_abits | input | 4 | Address bits per row/column half (clamped to 1..12) |
| cfg_ras_sel | input | 2 | Row strobe choice: 2 selects line 1, anything else line 0 |
| ma | output | 12 | Multiplexed row/column address |
| ras_n | output | 2 | Active-low row strobes |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Active-low write enable |
| dq_out | output | 8 | Data driven to the memory on writes |
| dq_oe | output | 1 | Output enable for `dq_out` |
| dq_in | input | 8 | Data returned by the memory |
| rd_data | output | 8 | Byte read, valid while `done` is 1 |
| done | output | 1 | One-cycle read completion pulse |

## Verification
The following properties are checked on every cycle:
- the quiet idle state;
- the drop of ready after acceptance;
- that only one row strobe is low at a time;
- that the data output enable implies write-enable;
- that write-enable comes before the row strobe, and the column strobe is released after the row strobe;
- that the address is stable before each strobe falls.

The address split under each bit-count setting, including the clamped values, can only be shown by the bench scenarios. The same holds for the choice of strobe line, the byte written and the byte read back through a behavioural memory, the exact busy and completion cycle counts, and the fact that inputs changed during an access are ignored.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ROW,
    ST_COLSET,
    ST_CAS,
    ST_RASOFF,
    ST_CASOFF,
    ST_DATAOFF,
    ST_PRE
  } seq_state_t;
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int MA_W  = 12,
  parameter int LIN_W = 2 * MA_W,
  parameter int ABW   = $clog2(MA_W + 1)
) (
  input  logic [LIN_W-1:0] addr,
  input  logic [ABW-1:0]   abits_raw,
  output logic [MA_W-1:0]  row,
  output logic [MA_W-1:0]  col
);
  logic [ABW-1:0]  ab;
  logic [MA_W-1:0] mask;
  logic [MA_W-1:0] shifted;

  // clamp the bit count into 1..MA_W
  always_comb begin
    if (abits_raw == '0)
      ab = ABW'(1);
    else if (int'(abits_raw) > MA_W)
      ab = ABW'(MA_W);
    else
      ab = abits_raw;
  end

  for (genvar i = 0; i < MA_W; i++) begin : g_mask
    assign mask[i] = (ab > ABW'(i));
  end

  assign shifted = MA_W'(addr >> ab);
  assign row     = shifted & mask;
  assign col     = addr[MA_W-1:0] & mask;
endmodule

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/dram_byte_seq.sv
module dram_byte_seq #(
  parameter int MA_W    = 12,
  parameter int DW      = 8,
  parameter int T_SETUP = 2,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_PRE   = 2,
  parameter int CNT_W   = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [2*MA_W-1:0]            req_addr,
  input  logic [DW-1:0]                req_wdata,
  input  logic [$clog2(MA_W+1)-1:0]    cfg_abits,
  input  logic [1:0]                   cfg_ras_sel,
  output logic [MA_W-1:0]              ma,
  output logic [1:0]                   ras_n,
  output logic                         cas_n,
  output logic                         we_n,
  output logic [DW-1:0]                dq_out,
  output logic                         dq_oe,
  input  logic [DW-1:0]                dq_in,
  output logic [DW-1:0]                rd_data,
  output logic                         done
);
  import dram_seq_pkg::*;

  localparam int LIN_W = 2 * MA_W;
  localparam int ABW   = $clog2(MA_W + 1);
  localparam int TS_E  = (T_SETUP < 1) ? 1 : T_SETUP;
  localparam int TR_E  = (T_RCD   < 1) ? 1 : T_RCD;
  localparam int TC_E  = (T_CAS   < 1) ? 1 : T_CAS;
  localparam int TP_E  = (T_PRE   < 1) ? 1 : T_PRE;

  function automatic logic [CNT_W-1:0] phase_len_m1(input seq_state_t s);
    case (s)
      ST_SETUP:  return CNT_W'(TS_E - 1);
      ST_ROW:    return CNT_W'(TR_E - 1);
      ST_COLSET: return CNT_W'(TS_E - 1);
      ST_CAS:    return CNT_W'(TC_E - 1);
      ST_PRE:    return CNT_W'(TP_E - 1);
      default:   return '0;
    endcase
  endfunction

  seq_state_t state_q, state_d;
  logic       accept;
  logic       tmr_last;

  // captured request
  logic [LIN_W-1:0] addr_q, addr_d;
  logic             wr_q, wr_d;
  logic [DW-1:0]    wdata_q, wdata_d;
  logic [ABW-1:0]   abits_q, abits_d;
  logic             rsel_q, rsel_d;

  logic [MA_W-1:0]  row_a, col_a;

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    addr_d  = accept ? req_addr : addr_q;
    wr_d    = accept ? req_write : wr_q;
    wdata_d = accept ? req_wdata : wdata_q;
    abits_d = accept ? cfg_abits : abits_q;
    rsel_d  = accept ? (cfg_ras_sel == 2'd2) : rsel_q;
  end

  dram_addr_split #(.MA_W(MA_W), .LIN_W(LIN_W), .ABW(ABW)) u_split (
    .addr      (addr_d),
    .abits_raw (abits_d),
    .row       (row_a),
    .col       (col_a)
  );

  dram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (state_d != state_q),
    .load_val (phase_len_m1(state_d)),
    .last     (tmr_last)
  );

  // sequence walk
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_SETUP;
      ST_SETUP:   if (tmr_last)  state_d = ST_ROW;
      ST_ROW:     if (tmr_last)  state_d = ST_COLSET;
      ST_COLSET:  if (tmr_last)  state_d = ST_CAS;
      ST_CAS:     if (tmr_last)  state_d = ST_RASOFF;
      ST_RASOFF:                 state_d = ST_CASOFF;
      ST_CASOFF:                 state_d = wr_q ? ST_DATAOFF : ST_PRE;
      ST_DATAOFF:                state_d = ST_PRE;
      ST_PRE:     if (tmr_last)  state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  // output decode of the next state, registered below
  logic [MA_W-1:0] ma_d;
  logic            ras_low_d, cas_low_d, we_low_d, oe_d, done_d;

  always_comb begin
    ma_d      = '0;
    ras_low_d = 1'b0;
    cas_low_d = 1'b0;
    we_low_d  = 1'b0;
    oe_d      = 1'b0;
    case (state_d)
      ST_SETUP: begin
        ma_d = row_a; we_low_d = wr_d; oe_d = wr_d;
      end
      ST_ROW: begin
        ma_d = row_a; ras_low_d = 1'b1; we_low_d = wr_d; oe_d = wr_d;
      end
      ST_COLSET: begin
        ma_d = col_a; ras_low_d = 1'b1; we_low_d = wr_d; oe_d = wr_d;
      end
      ST_CAS: begin
        ma_d = col_a; ras_low_d = 1'b1; cas_low_d = 1'b1;
        we_low_d = wr_d; oe_d = wr_d;
      end
      ST_RASOFF: begin
        ma_d = col_a; cas_low_d = 1'b1; we_low_d = wr_d; oe_d = wr_d;
      end
      ST_CASOFF: begin
        ma_d = col_a; we_low_d = wr_d; oe_d = wr_d;
      end
      ST_DATAOFF: begin
        ma_d = col_a; we_low_d = wr_d;
      end
      default: ;
    endcase
  end

  assign done_d = (state_q == ST_CAS) && (state_d == ST_RASOFF) && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      abits_q   <= '0;
      rsel_q    <= 1'b0;
      req_ready <= 1'b1;
      ma        <= '0;
      ras_n     <= 2'b11;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
    end else begin
      state_q   <= state_d;
      addr_q    <= addr_d;
      wr_q      <= wr_d;
      wdata_q   <= wdata_d;
      abits_q   <= abits_d;
      rsel_q    <= rsel_d;
      req_ready <= (state_d == ST_IDLE);
      ma        <= ma_d;
      ras_n[0]  <= !(ras_low_d && !rsel_d);
      ras_n[1]  <= !(ras_low_d && rsel_d);
      cas_n     <= !cas_low_d;
      we_n      <= !we_low_d;
      dq_out    <= oe_d ? wdata_d : '0;
      dq_oe     <= oe_d;
      done      <= done_d;
      if (done_d)
        rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/dram_byte_seq_chk.sv
module dram_byte_seq_chk #(
  parameter int MA_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [MA_W-1:0] ma,
  input logic [1:0]      ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            dq_oe,
  input logic            done
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> ((ras_n == 2'b11) && cas_n && we_n && !dq_oe && !done));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  one_ras_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ras_n));

  // R6
  oe_with_we_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !we_n);

  // R6
  we_before_ras_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (ras_n == 2'b11));

  // R6
  ras_off_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> (ras_n == 2'b11));

  // R7
  done_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!req_ready && we_n && !dq_oe));

  // R8
  row_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(&ras_n) |-> $stable(ma));

  // R8
  col_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> $stable(ma));
endmodule

bind dram_byte_seq dram_byte_seq_chk #(.MA_W(MA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ma        (ma),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .dq_oe     (dq_oe),
  .done      (done)
);

// File: tb/dram_byte_seq_test.sv
`timescale 1ns/1ps
module dram_byte_seq_test;
  localparam int MA_W = 12;
  localparam int DW   = 8;
  localparam int EXP_DONE  = 9;
  localparam int EXP_BUSYW = 13;
  localparam int EXP_BUSYR = 12;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [2*MA_W-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0] cfg_abits = 4'd8;
  logic [1:0] cfg_ras_sel = 2'd1;
  logic [MA_W-1:0] ma;
  logic [1:0] ras_n;
  logic cas_n, we_n, dq_oe, done;
  logic [DW-1:0] dq_out, rd_data;
  logic [DW-1:0] dq_in = '0;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dram_byte_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_abits(cfg_abits), .cfg_ras_sel(cfg_ras_sel), .ma(ma), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .rd_data(rd_data), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // behavioural memory and strobe monitor
  bit [7:0] model_mem [int];
  bit [7:0] ref_mem   [int];
  logic [1:0] prev_ras = 2'b11;
  logic prev_cas = 1;
  int mon_idx, mon_row, mon_col, mon_wd, mon_we, mon_oe;

  function automatic bit [7:0] dflt(input int key);
    return key[7:0] ^ key[15:8] ^ key[23:16] ^ 8'h3C;
  endfunction

  function automatic int mkkey(input int idx, input int row, input int col);
    return (idx << 24) | (row << 12) | col;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ras == 2'b11 && ras_n != 2'b11) begin
        mon_idx = ras_n[1] ? 0 : 1;
        mon_row = int'(ma);
      end
      if (prev_cas && !cas_n) begin
        mon_col = int'(ma);
        mon_we  = int'(we_n);
        mon_oe  = int'(dq_oe);
        mon_wd  = int'(dq_out);
        if (!we_n)
          model_mem[mkkey(mon_idx, mon_row, mon_col)] = dq_out;
        else if (model_mem.exists(mkkey(mon_idx, mon_row, mon_col)))
          dq_in = model_mem[mkkey(mon_idx, mon_row, mon_col)];
        else
          dq_in = dflt(mkkey(mon_idx, mon_row, mon_col));
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  function automatic int eff_bits(input logic [3:0] ab);
    if (ab == 0) return 1;
    if (ab > 12) return 12;
    return int'(ab);
  endfunction

  task automatic run_txn(input bit wr, input logic [23:0] a, input logic [7:0] d,
                         input logic [3:0] ab, input logic [1:0] sel, input bit scramble);
    int n, er, ec, ei, key, busy, done_at;
    logic [7:0] got, expd;
    n  = eff_bits(ab);
    er = int'((a >> n) & ((24'd1 << n) - 1));
    ec = int'(a & ((24'd1 << n) - 1));
    ei = (sel == 2'd2) ? 1 : 0;
    key = mkkey(ei, er, ec);
    mon_idx = -1; mon_row = -1; mon_col = -1;
    got = '0; done_at = 0; busy = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    cfg_abits = ab; cfg_ras_sel = sel;
    @(negedge clk);
    req_valid = 0;
    if (scramble) begin
      req_addr = ~a; req_wdata = ~d; req_write = !wr;
      cfg_abits = ab + 4'd3; cfg_ras_sel = sel + 2'd1;
    end
    while (!req_ready && busy < 1000) begin
      busy++;
      if (done && done_at == 0) begin done_at = busy; got = rd_data; end
      @(negedge clk);
    end
    check(scramble ? "R9" : "R3", "row", mon_row, er);
    check(scramble ? "R9" : "R3", "col", mon_col, ec);
    check(scramble ? "R9" : "R5", "ras line", mon_idx, ei);
    if (wr) begin
      ref_mem[key] = d;
      check("R6", "we_n at cas", mon_we, 0);
      check("R6", "oe at cas", mon_oe, 1);
      check("R6", "wdata at cas", mon_wd, int'(d));
      check("R2", "write busy", busy, EXP_BUSYW);
      check("R7", "no done on write", done_at, 0);
    end else begin
      expd = ref_mem.exists(key) ? ref_mem[key] : dflt(key);
      check("R7", "we_n at cas", mon_we, 1);
      check("R7", "oe at cas", mon_oe, 0);
      check("R7", "read data", int'(got), int'(expd));
      check("R7", "done cycle", done_at, EXP_DONE);
      check("R2", "read busy", busy, EXP_BUSYR);
    end
    check("R1", "idle strobes", int'({ras_n, cas_n, we_n, dq_oe, done}), 'b111100);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", "ready", int'(req_ready), 1);
    check("R1", "ras_n", int'(ras_n), 3);
    check("R1", "cas/we/oe/done", int'({cas_n, we_n, dq_oe, done}), 'b1100);

    // directed corners
    run_txn(1, 24'hFFFFFF, 8'hA5, 4'd12, 2'd1, 0);   // R3 full width
    run_txn(0, 24'hFFFFFF, 8'h00, 4'd12, 2'd1, 0);
    run_txn(1, 24'h000003, 8'h5A, 4'd1,  2'd2, 0);   // R5 line 1
    run_txn(0, 24'h000003, 8'h00, 4'd0,  2'd2, 0);   // R4 zero acts as 1
    run_txn(1, 24'h123456, 8'h3C, 4'd15, 2'd3, 0);   // R4 clamp, R5 other -> line 0
    run_txn(0, 24'h123456, 8'h00, 4'd12, 2'd0, 0);
    run_txn(1, 24'h00ABCD, 8'h77, 4'd8,  2'd1, 1);   // R9 inputs scrambled while busy
    run_txn(0, 24'h00ABCD, 8'h00, 4'd8,  2'd1, 1);
    run_txn(0, 24'h0F0F0F, 8'h00, 4'd5,  2'd2, 0);   // unwritten cell

    for (int i = 0; i < 250; i++) begin
      logic [23:0] a;
      a = 24'($urandom);
      if (i % 3 == 2) a = a & 24'h000FFF;
      run_txn(1'($urandom), a, 8'($urandom), 4'($urandom_range(0, 15)),
              2'($urandom_range(0, 3)), (i % 17) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule